// File: doc/BRIEF.md
# Two-Line GPIO Controller with Data-Ready Strobe

This block owns two bidirectional general-purpose pads. Software reaches it through a small synchronous register port that carries an address, write data, a write strobe and combinational read data. One register sets each line's direction and driven level and returns the live pad level for lines that are inputs. A second register turns on a data-ready strobe, sets its active level and picks the pad that carries it.

The data path gives a one-cycle sample tick at the start of each sample period. Each tick starts a strobe that stays active for one fifth of the nominal sample period, which is set by a parameter. While the strobe is enabled, the chosen pad is driven as an output and carries the strobe, whatever the GPIO register holds. The other pad keeps its GPIO behaviour. Pad inputs pass through a two-flop synchronizer before they can be read back.

Top module: `gpio_drdy_ctrl`

## Requirements
- R1: After reset, both registers read 0x0000. Both pad output enables and both pad outputs are low.
- R2: At GPIO register address 0, bit 0 sets the direction of line 1 (pad index 0) and bit 1 sets the direction of line 2 (pad index 1). A 1 makes the line an output and a 0 makes it an input. The pad output enable follows the bit when the strobe does not own that pad.
- R3: GPIO register bits 8 and 9 set the level driven on lines 1 and 2 (1 = high). When a line is an input, its pad output is held low. Writing 0x0202 makes line 2 an output driving high and line 1 an input. Writing 0x0000 makes both lines inputs.
- R4: When a line is an input, reading bit 8 or bit 9 returns that pad's level, delayed by two clock edges through the synchronizer. When a line is an output, the bit reads back the stored level.
- R5: Bits that are not defined read as zero and ignore writes. These are bits 15:10 and 7:2 of the GPIO register and bits 15:3 of the misc register at address 1. Any other address reads zero and a write to it changes no register.
- R6: The misc register keeps bits 2 (strobe enable), 1 (polarity, 1 = active high) and 0 (pad select, 1 = line 2) and reads them back.
- R7: When the strobe is enabled, the selected pad's output enable is high and its output carries the strobe. The unselected pad follows its GPIO settings.
- R8: The edge that samples a tick starts the strobe. The strobe then stays active for exactly PERIOD_CYCLES/5 cycles and is inactive otherwise.
- R9: With polarity 1 the strobe pad is high while the strobe is active and low otherwise. With polarity 0 the levels are inverted.
- R10: A tick that arrives while the strobe is active restarts the full active window.
- R11: A cycle with the write strobe low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 16 | Read data for addr_i |
| sample_tick_i | input | 1 | One-cycle pulse at the start of each sample period |
| pad_i | input | 2 | Pad input levels (asynchronous) |
| pad_o | output | 2 | Pad output levels |
| pad_oe_o | output | 2 | Pad output enables |

## Verification
The assertions run on every cycle and cover these points:
- the strobe starts on a tick and stays idle until the next one;
- the strobe counter never goes past its window;
- registers hold their values when the write strobe is low;
- the pad output enables follow the strobe ownership rule.

Some behaviours only the bench's scenarios can show:
- the full pad and readback picture for every direction, level and pad-input combination;
- the two-edge synchronizer latency;
- the exact strobe waveform and window length for every enable, polarity and select setting;
- the restart on a retriggering tick.

// File: rtl/gpio_drdy_pkg.sv
package gpio_drdy_pkg;
  localparam int N_PINS  = 2;
  localparam int REG_W   = 16;
  localparam int DIR_LSB = 0;
  localparam int LVL_LSB = 8;
  localparam int MSC_SEL = 0;
  localparam int MSC_POL = 1;
  localparam int MSC_EN  = 2;

  typedef struct packed {
    logic en;
    logic pol;
    logic sel;
  } drdy_cfg_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s0_q, s1_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s0_q <= 1'b0;
        s1_q <= 1'b0;
      end else begin
        s0_q <= d_i[g];
        s1_q <= s0_q;
      end
    end
    assign q_o[g] = s1_q;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_drdy_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] GPIO_ADDR = 'd0,
  parameter logic [ADDR_W-1:0] MISC_ADDR = 'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  input  logic [N_PINS-1:0] pad_sync_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] lvl_o,
  output drdy_cfg_t         cfg_o
);
  logic [N_PINS-1:0] dir_q, lvl_q;
  drdy_cfg_t         cfg_q;

  wire wr_gpio = we_i && (addr_i == GPIO_ADDR);
  wire wr_misc = we_i && (addr_i == MISC_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lvl_q <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_gpio) begin
        dir_q <= wdata_i[DIR_LSB +: N_PINS];
        lvl_q <= wdata_i[LVL_LSB +: N_PINS];
      end
      if (wr_misc) begin
        cfg_q.en  <= wdata_i[MSC_EN];
        cfg_q.pol <= wdata_i[MSC_POL];
        cfg_q.sel <= wdata_i[MSC_SEL];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == GPIO_ADDR) begin
      for (int i = 0; i < N_PINS; i++) begin
        rdata_o[DIR_LSB+i] = dir_q[i];
        rdata_o[LVL_LSB+i] = dir_q[i] ? lvl_q[i] : pad_sync_i[i];
      end
    end else if (addr_i == MISC_ADDR) begin
      rdata_o[MSC_EN]  = cfg_q.en;
      rdata_o[MSC_POL] = cfg_q.pol;
      rdata_o[MSC_SEL] = cfg_q.sel;
    end
  end

  assign dir_o = dir_q;
  assign lvl_o = lvl_q;
  assign cfg_o = cfg_q;

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(dir_q) && $stable(lvl_q) && $stable(cfg_q)));
  p_foreign_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != GPIO_ADDR && addr_i != MISC_ADDR) |=> ($stable(dir_q) && $stable(lvl_q) && $stable(cfg_q)));
  p_unused_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[REG_W-1:LVL_LSB+N_PINS] == '0);
endmodule

// File: rtl/drdy_strobe.sv
module drdy_strobe #(
  parameter int PERIOD_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic active_o
);
  localparam int PULSE_CYCLES = PERIOD_CYCLES / 5;
  localparam int CNT_W        = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (tick_i)         cnt_q <= PULSE_LD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  p_tick_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> active_o);
  p_idle_stays_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !active_o) |=> !active_o);
  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PULSE_LD);
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_drdy_pkg::*;
(
  input  logic [N_PINS-1:0] dir_i,
  input  logic [N_PINS-1:0] lvl_i,
  input  drdy_cfg_t         cfg_i,
  input  logic              strobe_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o
);
  wire strobe_lvl = cfg_i.pol ? strobe_i : ~strobe_i;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pad
    wire own = cfg_i.en && (cfg_i.sel == 1'(g));
    assign pad_oe_o[g] = own | dir_i[g];
    assign pad_o[g]    = own ? strobe_lvl : (dir_i[g] & lvl_i[g]);
  end
endmodule

// File: rtl/gpio_drdy_ctrl.sv
module gpio_drdy_ctrl
  import gpio_drdy_pkg::*;
#(
  parameter int                ADDR_W        = 4,
  parameter logic [ADDR_W-1:0] GPIO_ADDR     = 'd0,
  parameter logic [ADDR_W-1:0] MISC_ADDR     = 'd1,
  parameter int                PERIOD_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              we_i,
  output logic [15:0]       rdata_o,
  input  logic              sample_tick_i,
  input  logic [1:0]        pad_i,
  output logic [1:0]        pad_o,
  output logic [1:0]        pad_oe_o
);
  logic [N_PINS-1:0] pad_sync, dir, lvl;
  drdy_cfg_t         cfg;
  logic              strobe;

  gpio_in_sync #(.N(N_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(pad_sync)
  );

  gpio_regs #(.ADDR_W(ADDR_W), .GPIO_ADDR(GPIO_ADDR), .MISC_ADDR(MISC_ADDR)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .pad_sync_i(pad_sync), .rdata_o(rdata_o),
    .dir_o(dir), .lvl_o(lvl), .cfg_o(cfg)
  );

  drdy_strobe #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(sample_tick_i), .active_o(strobe)
  );

  gpio_pad_mux u_mux (
    .dir_i(dir), .lvl_i(lvl), .cfg_i(cfg), .strobe_i(strobe),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o)
  );

  p_owns_line1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.en && !cfg.sel) |-> (pad_oe_o[0] && pad_oe_o[1] == dir[1]));
  p_owns_line2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.en && cfg.sel) |-> (pad_oe_o[1] && pad_oe_o[0] == dir[0]));
  p_gpio_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.en |-> (pad_oe_o == dir));
endmodule

// File: tb/gpio_drdy_ctrl_bench.sv
module gpio_drdy_ctrl_bench;
  localparam int PERIOD = 20;
  localparam int PULSE  = PERIOD / 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;
  logic        tick = 1'b0;
  logic [1:0]  pad_in = '0;
  logic [1:0]  pad_out, pad_oe;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpio_drdy_ctrl #(.PERIOD_CYCLES(PERIOD)) u_gpio_drdy_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .sample_tick_i(tick), .pad_i(pad_in),
    .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 oe", {14'b0, pad_oe}, 16'h0);
    chk("R1 out", {14'b0, pad_out}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 gpio", 4'd0, 16'h0);
    rd_chk("R1 misc", 4'd1, 16'h0);

    // R2 R3 R4: every direction/level/pad combination
    for (int g = 0; g < 16; g++) begin
      for (int p = 0; p < 4; p++) begin
        logic [1:0] d, l, pp;
        logic [15:0] exp_rb;
        d = g[1:0]; l = g[3:2]; pp = p[1:0];
        wr(4'd0, {6'b0, l, 6'b0, d});
        pad_in = pp;
        repeat (2) @(negedge clk);
        #1;
        chk("R2 oe", {14'b0, pad_oe}, {14'b0, d});
        chk("R3 out", {14'b0, pad_out}, {14'b0, d & l});
        exp_rb = {6'b0, (d & l) | (~d & pp), 6'b0, d};
        rd_chk("R4 readback", 4'd0, exp_rb);
      end
    end

    // R3 documented examples
    wr(4'd0, 16'h0202); #1;
    chk("R3 0x0202 oe", {14'b0, pad_oe}, 16'h2);
    chk("R3 0x0202 out", {14'b0, pad_out}, 16'h2);
    wr(4'd0, 16'h0000); #1;
    chk("R3 0x0000 oe", {14'b0, pad_oe}, 16'h0);

    // R4 synchronizer latency
    pad_in = 2'b00;
    repeat (3) @(negedge clk);
    pad_in = 2'b11;
    @(negedge clk);
    rd_chk("R4 one edge", 4'd0, 16'h0000);
    @(negedge clk);
    rd_chk("R4 two edges", 4'd0, 16'h0300);
    pad_in = 2'b00;
    repeat (2) @(negedge clk);

    // R5 unused bits, foreign address
    wr(4'd0, 16'hFFFF);
    rd_chk("R5 gpio mask", 4'd0, 16'h0303);
    wr(4'd1, 16'hFFF8);
    rd_chk("R5 misc mask", 4'd1, 16'h0000);
    wr(4'd5, 16'h0000);
    rd_chk("R5 foreign read", 4'd5, 16'h0000);
    rd_chk("R5 foreign write gpio", 4'd0, 16'h0303);

    // R11 write strobe low
    addr = 4'd0; wdata = 16'h0000; we = 1'b0;
    @(negedge clk);
    rd_chk("R11 no write", 4'd0, 16'h0303);

    // R6 misc readback
    for (int m = 0; m < 8; m++) begin
      wr(4'd1, 16'(m));
      rd_chk("R6 misc", 4'd1, 16'(m));
    end

    // R7 R8 R9: all enable/polarity/select settings, line1 output high, line2 input
    wr(4'd0, 16'h0101);
    for (int m = 0; m < 8; m++) begin
      logic en, pol, sel;
      en = m[2]; pol = m[1]; sel = m[0];
      wr(4'd1, 16'(m));
      repeat (PULSE + 2) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      for (int j = 1; j <= PULSE + 2; j++) begin
        logic act;
        logic [1:0] eoe, eout;
        act = (j <= PULSE);
        eoe = 2'b01; eout = 2'b01;
        if (en) begin
          eoe[sel] = 1'b1;
          eout[sel] = pol ? act : ~act;
        end
        #1;
        chk("R7 R8 oe", {14'b0, pad_oe}, {14'b0, eoe});
        chk("R8 R9 out", {14'b0, pad_out}, {14'b0, eout});
        @(negedge clk);
      end
    end

    // R10 retrigger while active
    wr(4'd1, 16'h0006);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    @(negedge clk);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    for (int j = 1; j <= PULSE + 1; j++) begin
      #1;
      chk("R10 retrigger", {15'b0, pad_out[0]}, {15'b0, (j <= PULSE)});
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule